// File: doc/BRIEF.md
# Block Transfer and Search Engine

This block performs memory-to-memory byte copies and byte searches for a CPU with a 16-bit address space. A command loads a source pointer, a destination pointer, a 16-bit byte counter, the incoming flag byte and, for searches, an 8-bit key. The engine then works through the block one byte per step on a synchronous memory port. Each access is held until the memory answers with ready.

A copy step reads the byte at the source pointer and writes it to the destination pointer. A search step reads the byte at the source pointer and subtracts it from the key; the result is used only to update flags. After each step both pointers move by +1 or -1, as the command selects, and the counter drops by one. A single-step command does exactly one step. A repeating copy runs until the counter reaches zero. A repeating search also stops at the first byte equal to the key. When the command ends, a one-cycle done pulse presents the final pointers, counter and flags.

Top module: `blkx_engine`

## Requirements
- R1: A copy step reads the byte at the source pointer, writes it to the destination pointer, then moves both pointers by +1 (direction input 0) or -1 (direction input 1) and lowers the counter by one.
- R2: A repeating copy keeps stepping until the counter reaches zero, so it ends with the counter at 0 and the parity/overflow flag (bit 2) at 0.
- R3: A search step never writes memory and leaves the destination pointer unchanged. It computes key minus memory byte and sets sign (bit 7) to the result's top bit, zero (bit 6) when the result is zero, half-carry (bit 4) on a borrow out of the low nibble, and N (bit 1) to 1. Carry (bit 0) keeps its loaded value.
- R4: A repeating search stops after the first step whose byte equals the key, or when the counter reaches zero, whichever comes first.
- R5: After every step, flag bit 2 is 1 when the new counter is nonzero and 0 when it is zero. Copy steps clear bits 4 and 1.
- R6: Pointers and counter wrap modulo 65536. A repeating command loaded with a counter of zero first steps it to 0xFFFF and goes on.
- R7: `busy_o` is high from the cycle after an accepted start until the done pulse, and `start_i` is ignored while busy. Reset leaves the engine idle with no request and no done.
- R8: While the memory holds ready low, the request, write enable, address and write data stay stable, so any number of wait cycles is tolerated.
- R9: A command with the repeat input at 0 performs exactly one step, whatever the counter value.
- R10: Flag bits 5 and 3, and every bit a step does not update, keep the value loaded with the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, accepted only when idle |
| op_cmp_i | input | 1 | 0 copy, 1 search |
| dir_dec_i | input | 1 | 0 increment pointers, 1 decrement |
| rep_i | input | 1 | 1 repeat, 0 single step |
| key_i | input | 8 | Search key |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 16 | Initial byte counter |
| flags_i | input | 8 | Flag byte loaded with the command |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access completes in a cycle with request and ready |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| cnt_o | output | 16 | Current counter |
| flags_o | output | 8 | Current flag byte |

## Verification
On every cycle the assertions check that a stalled access holds its request, address, direction and data. They also check that the counter only ever falls by one while busy, that a search never writes, and that the done pulse carries a parity/overflow bit agreeing with the counter. A repeating copy must finish at zero, and done never overlaps busy. Only the directed scenarios can show the copied bytes, the stop point of a search, the flag values from a subtraction, wrap-around across address zero and the rejection of a second start. A reference model in the bench supplies the expected memory image and final state for each of these.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic is_cmp;
    logic dec;
    logic rep;
  } xfer_mode_t;

  localparam int FL_S  = 7;
  localparam int FL_Z  = 6;
  localparam int FL_H  = 4;
  localparam int FL_PV = 2;
  localparam int FL_N  = 1;
  localparam int FL_C  = 0;
endpackage

// File: rtl/blkx_ptr_step.sv
module blkx_ptr_step #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dec_i,
  input  logic          move_dst_i,
  output logic [AW-1:0] src_nx_o,
  output logic [AW-1:0] dst_nx_o,
  output logic [CW-1:0] cnt_nx_o,
  output logic          cnt_nz_nx_o
);
  logic [AW-1:0] delta;

  // +1 or -1 in two's complement; wraps naturally modulo 2**AW
  assign delta       = dec_i ? {AW{1'b1}} : AW'(1);
  assign src_nx_o    = src_i + delta;
  assign dst_nx_o    = move_dst_i ? (dst_i + delta) : dst_i;
  assign cnt_nx_o    = cnt_i - CW'(1);
  assign cnt_nz_nx_o = |cnt_nx_o;
endmodule

// File: rtl/blkx_cmp_flags.sv
module blkx_cmp_flags #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] key_i,
  input  logic [DW-1:0] data_i,
  output logic          sign_o,
  output logic          zero_o,
  output logic          half_o
);
  localparam int HW = DW / 2;
  logic [DW-1:0] diff;

  assign diff   = key_i - data_i;
  assign sign_o = diff[DW-1];
  assign zero_o = (diff == '0);
  assign half_o = (key_i[HW-1:0] < data_i[HW-1:0]);
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  xfer_mode_t mode_i,
  input  logic       rdy_i,
  input  logic       match_i,
  input  logic       cnt_nz_nx_i,
  output logic       load_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic       grab_o,
  output logic       step_o,
  output logic       finish_o
);
  seq_state_e state_q, state_d;
  logic       cont;

  always_comb begin
    state_d  = state_q;
    load_o   = 1'b0;
    grab_o   = 1'b0;
    step_o   = 1'b0;
    finish_o = 1'b0;
    cont     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (rdy_i) begin
          if (mode_i.is_cmp) begin
            step_o   = 1'b1;
            cont     = mode_i.rep && cnt_nz_nx_i && !match_i;
            finish_o = !cont;
            state_d  = cont ? ST_READ : ST_IDLE;
          end else begin
            grab_o  = 1'b1;
            state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (rdy_i) begin
          step_o   = 1'b1;
          cont     = mode_i.rep && cnt_nz_nx_i;
          finish_o = !cont;
          state_d  = cont ? ST_READ : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign rd_o = (state_q == ST_READ);
  assign wr_o = (state_q == ST_WRITE);
endmodule

// File: rtl/blkx_engine.sv
module blkx_engine
  import blkx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_cmp_i,
  input  logic          dir_dec_i,
  input  logic          rep_i,
  input  logic [DW-1:0] key_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [7:0]    flags_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic [7:0]    flags_o
);
  xfer_mode_t    mode_q, mode_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] key_q, key_d, data_q, data_d;
  logic [7:0]    flags_q, flags_d;
  logic          done_q, done_d;

  logic          load, rd, wr, grab, step, finish;
  logic [AW-1:0] src_nx, dst_nx;
  logic [CW-1:0] cnt_nx;
  logic          cnt_nz_nx;
  logic          c_sign, c_zero, c_half;

  blkx_ptr_step #(.AW(AW), .CW(CW)) u_step (
    .src_i       (src_q),
    .dst_i       (dst_q),
    .cnt_i       (cnt_q),
    .dec_i       (mode_q.dec),
    .move_dst_i  (!mode_q.is_cmp),
    .src_nx_o    (src_nx),
    .dst_nx_o    (dst_nx),
    .cnt_nx_o    (cnt_nx),
    .cnt_nz_nx_o (cnt_nz_nx)
  );

  blkx_cmp_flags #(.DW(DW)) u_cmp (
    .key_i  (key_q),
    .data_i (mem_rdata_i),
    .sign_o (c_sign),
    .zero_o (c_zero),
    .half_o (c_half)
  );

  blkx_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_q),
    .rdy_i       (mem_rdy_i),
    .match_i     (c_zero),
    .cnt_nz_nx_i (cnt_nz_nx),
    .load_o      (load),
    .rd_o        (rd),
    .wr_o        (wr),
    .grab_o      (grab),
    .step_o      (step),
    .finish_o    (finish)
  );

  // next-state for the datapath
  always_comb begin
    mode_d  = mode_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    key_d   = key_q;
    data_d  = data_q;
    flags_d = flags_q;
    done_d  = finish;
    if (load) begin
      mode_d  = '{is_cmp: op_cmp_i, dec: dir_dec_i, rep: rep_i};
      src_d   = src_i;
      dst_d   = dst_i;
      cnt_d   = cnt_i;
      key_d   = key_i;
      flags_d = flags_i;
    end
    if (grab) data_d = mem_rdata_i;
    if (step) begin
      src_d          = src_nx;
      dst_d          = dst_nx;
      cnt_d          = cnt_nx;
      flags_d[FL_PV] = cnt_nz_nx;
      if (mode_q.is_cmp) begin
        flags_d[FL_S] = c_sign;
        flags_d[FL_Z] = c_zero;
        flags_d[FL_H] = c_half;
        flags_d[FL_N] = 1'b1;
      end else begin
        flags_d[FL_H] = 1'b0;
        flags_d[FL_N] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      key_q   <= '0;
      data_q  <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cnt_q   <= cnt_d;
      key_q   <= key_d;
      data_q  <= data_d;
      flags_q <= flags_d;
      done_q  <= done_d;
    end
  end

  assign mem_req_o   = rd | wr;
  assign mem_we_o    = wr;
  assign mem_addr_o  = wr ? dst_q : src_q;
  assign mem_wdata_o = data_q;
  assign busy_o      = rd | wr;
  assign done_o      = done_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cnt_o       = cnt_q;
  assign flags_o     = flags_q;
endmodule

// File: rtl/blkx_checker.sv
module blkx_checker #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_rdy_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] cnt_o,
  input logic [7:0]    flags_o,
  input logic          is_cmp,
  input logic          is_rep
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)) // R8
    else $error("AST_REQ_HELD");
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o && !mem_rdy_i |=> $stable(mem_wdata_o)) // R8
    else $error("AST_WDATA_HELD");
  AST_CNT_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) && !$stable(cnt_o) |-> cnt_o == $past(cnt_o) - CW'(1)) // R1
    else $error("AST_CNT_DOWN_ONE");
  AST_DONE_PV: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> flags_o[2] == (cnt_o != '0)) // R5
    else $error("AST_DONE_PV");
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o) // R7
    else $error("AST_DONE_IDLE");
  AST_SEARCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && is_cmp |-> !mem_we_o) // R3
    else $error("AST_SEARCH_NO_WRITE");
  AST_REPCOPY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && is_rep && !is_cmp |-> cnt_o == '0 && !flags_o[2]) // R2
    else $error("AST_REPCOPY_ZERO");
endmodule

bind blkx_engine blkx_checker #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdy_i   (mem_rdy_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cnt_o       (cnt_o),
  .flags_o     (flags_o),
  .is_cmp      (mode_q.is_cmp),
  .is_rep      (mode_q.rep)
);

// File: tb/sim_blkx_engine.sv
`timescale 1ns/1ps
module sim_blkx_engine;
  logic        clk, rst_n;
  logic        start, op_cmp, dir_dec, rep;
  logic [7:0]  key, fin;
  logic [15:0] src, dst, cnt;
  logic        req, we, rdy, busy, done;
  logic [15:0] addr, src_o, dst_o, cnt_o;
  logic [7:0]  wdata, rdata, flags_o;

  logic [7:0]  mem  [0:1023];
  logic [7:0]  rmem [0:1023];
  int          waits, wcnt;
  int          errors = 0, checks = 0;

  blkx_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_cmp_i(op_cmp),
    .dir_dec_i(dir_dec), .rep_i(rep), .key_i(key), .src_i(src),
    .dst_i(dst), .cnt_i(cnt), .flags_i(fin), .mem_req_o(req),
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_rdy_i(rdy), .busy_o(busy), .done_o(done),
    .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign rdata = mem[addr[9:0]];

  // memory with programmable wait states
  always @(negedge clk) rdy <= req && (wcnt >= waits);
  always @(posedge clk) begin
    if (req && rdy) begin
      wcnt <= 0;
      if (we) mem[addr[9:0]] <= wdata;
    end else if (req) wcnt <= wcnt + 1;
  end

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'((i * 37 + seed * 11) ^ (i >> 3));
      rmem[i] = mem[i];
    end
  endtask

  // Runs one command, compares against a bench reference model
  task automatic run(input string tag, input bit c, input bit d, input bit r,
                     input logic [7:0] k, input logic [15:0] s0,
                     input logic [15:0] d0, input logic [15:0] n0,
                     input logic [7:0] f0, input int w, input bit poke);
    logic [15:0] es, ed, en;
    logic [7:0]  ef, m, diff;
    bit          hit;
    int          t, bad;
    es = s0; ed = d0; en = n0; ef = f0;
    do begin
      hit = 0;
      if (c) begin
        m = rmem[es[9:0]]; diff = k - m;
        ef[7] = diff[7]; ef[6] = (diff == 0); ef[4] = (k[3:0] < m[3:0]);
        ef[1] = 1'b1; hit = (diff == 0);
      end else begin
        rmem[ed[9:0]] = rmem[es[9:0]];
        ef[4] = 1'b0; ef[1] = 1'b0;
        ed = d ? ed - 16'd1 : ed + 16'd1;
      end
      es = d ? es - 16'd1 : es + 16'd1;
      en = en - 16'd1;
      ef[2] = (en != 0);
    end while (r && en != 0 && !hit);

    waits = w;
    @(negedge clk);
    start = 1; op_cmp = c; dir_dec = d; rep = r; key = k;
    src = s0; dst = d0; cnt = n0; fin = f0;
    @(negedge clk);
    start = 0;
    if (poke) begin
      chk(busy === 1'b1, "R7", {tag, " busy after start"}, 32'(busy), 1);
      @(negedge clk);
      start = 1; op_cmp = ~c; rep = 0; src = 16'h0300; dst = 16'h0380;
      cnt = 16'h0001; fin = 8'h00;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (done !== 1'b1 && t < 20000) begin
      @(negedge clk); t++;
    end
    chk(done === 1'b1, "R7", {tag, " done seen"}, 32'(done), 1);
    chk(busy === 1'b0, "R7", {tag, " idle at done"}, 32'(busy), 0);
    chk(src_o === es, "R1", {tag, " src"}, 32'(src_o), 32'(es));
    chk(dst_o === ed, "R1", {tag, " dst"}, 32'(dst_o), 32'(ed));
    chk(cnt_o === en, "R4", {tag, " count"}, 32'(cnt_o), 32'(en));
    chk(flags_o === ef, "R5", {tag, " flags"}, 32'(flags_o), 32'(ef));
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== rmem[i]) bad++;
    chk(bad == 0, "R1", {tag, " memory image"}, 32'(bad), 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R7", {tag, " stays idle"},
        {30'd0, done, busy}, 0);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R7", "reset busy", 32'(busy), 0);
    chk(done === 1'b0, "R7", "reset done", 32'(done), 0);
    chk(req === 1'b0, "R7", "reset req", 32'(req), 0);
  endtask

  // R9 single copy step, count stays nonzero; R10 other bits kept
  task automatic t_copy_single;
    fill(1);
    run("R9 copy single", 0, 0, 0, 8'h00, 16'h0100, 16'h0200, 16'd5,
        8'hFF, 0, 0);
  endtask

  // R2 repeating copy, with waits (R8)
  task automatic t_copy_rep;
    fill(2);
    run("R2 copy rep inc", 0, 0, 1, 8'h00, 16'h0040, 16'h0140, 16'd9,
        8'h2B, 3, 0);
    run("R2 copy rep dec", 0, 1, 1, 8'h00, 16'h0250, 16'h0350, 16'd7,
        8'h16, 0, 0);
  endtask

  // R4 search stops on first match / on zero
  task automatic t_search;
    fill(3);
    rmem[16'h0083] = 8'h5A; mem[16'h0083] = 8'h5A;
    rmem[16'h0085] = 8'h5A; mem[16'h0085] = 8'h5A;
    run("R4 search match", 1, 0, 1, 8'h5A, 16'h0080, 16'h0010, 16'd10,
        8'h01, 1, 0);
    for (int i = 16'h0180; i < 16'h0186; i++) begin
      mem[i] = 8'h10; rmem[i] = 8'h10;
    end
    run("R4 search to zero", 1, 1, 1, 8'h33, 16'h0185, 16'h0020, 16'd4,
        8'h00, 2, 0);
  endtask

  // R3 single search flags: half borrow and carry preserved
  task automatic t_search_flags;
    fill(4);
    mem[16'h0090] = 8'h2F; rmem[16'h0090] = 8'h2F;
    run("R3 search borrow c1", 1, 0, 0, 8'h21, 16'h0090, 16'h0000, 16'd1,
        8'h29, 0, 0);
    run("R3 search equal c0", 1, 0, 0, 8'h2F, 16'h0090, 16'h0000, 16'd3,
        8'hA8, 0, 0);
  endtask

  // R6 wrap: counter zero, pointers across address 0
  task automatic t_wrap;
    fill(5);
    mem[16'h0001] = 8'hC3; rmem[16'h0001] = 8'hC3;
    for (int i = 1020; i < 1024; i++) begin
      mem[i] = 8'h00; rmem[i] = 8'h00;
    end
    mem[0] = 8'h00; rmem[0] = 8'h00;
    run("R6 search wrap", 1, 0, 1, 8'hC3, 16'hFFFE, 16'h0000, 16'd0,
        8'h00, 1, 0);
    run("R6 copy ptr wrap", 0, 1, 1, 8'h00, 16'h0001, 16'h0201, 16'd3,
        8'h00, 0, 0);
  endtask

  // R7 second start while busy is ignored
  task automatic t_ignore_start;
    fill(6);
    run("R7 ignore start", 0, 0, 1, 8'h00, 16'h0010, 16'h0110, 16'd6,
        8'h04, 1, 1);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; op_cmp = 0; dir_dec = 0; rep = 0; key = 0;
    src = 0; dst = 0; cnt = 0; fin = 0; waits = 0; wcnt = 0; rdy = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_copy_single;
    t_copy_rep;
    t_search;
    t_search_flags;
    t_wrap;
    t_ignore_start;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule